// File: doc/BRIEF.md
# Serial Debug Command Response Sequencer

This block is the command engine on the target side of a serial debug port. A host moves 16-bit words in full-duplex transfers. Each transfer hands the block one command or operand word. In the same transfer the block returns a response word that was prepared before the transfer began. Every response carries a status flag next to its 16 data bits.

The engine decodes a no-operation command, a register-read command and a memory-read command. A memory read takes a 32-bit address in two further transfers, high half first, and then starts the access. Register and memory accesses go out on a simple request port. An external responder finishes each access with a done flag, an error flag and 32 bits of read data. While an access is outstanding, every transfer returns a not-ready answer and its word is discarded. A finished result comes back over two transfers, high half first. The host puts the next opcode in the second of those two transfers, so commands pipeline back to back.

Command encodings (bits 15:12 are the opcode field):
- No-operation: 0x0000.
- Register read: 0x2000 plus the register index in the low bits.
- Memory read: 0x1000 plus the size in bits 5:4. The size codes are 0 for a byte, 1 for a 16-bit word and 2 for a 32-bit long word.

Top module: `dbg_cmd_seq`

## Requirements
- R1: Response codes, written as (status, data): command complete is (0, 0xFFFF), not-ready is (1, 0x0000), illegal command is (1, 0xFFFF) and bus error is (1, 0x0001).
- R2: A synchronous active-high reset puts the engine in the idle state that expects an opcode, with no access request and no response strobe. The first response after reset is not-ready.
- R3: Each transfer (one cycle of xfer_valid) gives exactly one one-cycle resp_valid pulse in the following cycle. Between transfers resp_valid stays low. Transfers are at least MIN_GAP cycles apart.
- R4: After a no-operation command (0x0000), the next transfer returns command complete.
- R5: These words return illegal command on the next transfer and start no access: any opcode 3 to 15; opcode 0 with nonzero low bits; a register read with stray bits above the index; a memory read with size code 3 or with nonzero bits 11:6 or 3:0.
- R6: A register read issued while core_halted is 1 raises acc_req for one cycle, with acc_is_mem=0, acc_size=2 and acc_reg equal to word bits 3:0. After the access completes, the next two transfers return the read data with status 0: bits 31:16 first, then bits 15:0.
- R7: A register read issued while core_halted is 0 starts no access, and the next transfer returns bus error.
- R8: For a memory read, the two transfers after the opcode carry address bits 31:16 and then 15:0, and both return not-ready. At the end of the second one, acc_req pulses with acc_is_mem=1, the full address and the size code taken from the opcode.
- R9: A transfer made while an access is outstanding returns not-ready, and its word has no effect on the command sequence.
- R10: An access that ends with acc_err returns one bus-error response in place of the result. The transfer that receives it is taken as the next opcode.
- R11: The transfer that returns the low result half is decoded as the next command's opcode.
- R12: With ZERO_FILL=1, a byte read returns the data in bits 7:0 of the low half, and every other result bit is 0. A word read returns the data in bits 15:0 of the low half, and the high half is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| core_halted | input | 1 | Core is halted; register reads are allowed |
| xfer_valid | input | 1 | One-cycle strobe: a serial transfer carrying xfer_word |
| xfer_word | input | WORD_W | Word shifted in from the host |
| resp_valid | output | 1 | Response of the last transfer is on resp_status/resp_data |
| resp_status | output | 1 | Status flag of the response |
| resp_data | output | WORD_W | Data of the response |
| acc_req | output | 1 | One-cycle access start |
| acc_is_mem | output | 1 | 1 for a memory access, 0 for a register access |
| acc_size | output | 2 | Access size code (0 byte, 1 word, 2 long) |
| acc_addr | output | ADDR_W | Memory address |
| acc_reg | output | REG_W | Register index |
| acc_done | input | 1 | One-cycle access completion |
| acc_err | input | 1 | Access ended in a bus error (valid with acc_done) |
| acc_rdata | input | 2*WORD_W | Read data (valid with acc_done) |

## Verification
The assertions assume the following about the inputs:
- xfer_valid pulses are spaced at least MIN_GAP cycles apart.
- acc_done arrives only while an access the engine started is still outstanding, and never in the cycle of the request itself.

The bench starts every transfer from a task that waits a fixed gap after each word. Its access responder counts a latency from the sampled request before it raises done. The latency is chosen as a whole number of transfer spacings plus half a gap. This puts the completion reliably between two transfers, whether the test wants zero, one or two not-ready answers.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_AHI,
      ST_ALO,
      ST_BUSY,
      ST_RHI,
      ST_RLO
   } seq_state_t;

   typedef enum logic [2:0] {
      K_NOP,
      K_ILL,
      K_REGRD,
      K_REGERR,
      K_MEMRD
   } cmd_kind_t;

   typedef struct packed {
      logic        s;
      logic [15:0] d;
   } resp_t;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;

   localparam logic [3:0] OP_NOP = 4'h0;
   localparam logic [3:0] OP_MRD = 4'h1;
   localparam logic [3:0] OP_RRD = 4'h2;

   localparam resp_t RSP_DONE = '{s: 1'b0, d: 16'hFFFF};
   localparam resp_t RSP_NRDY = '{s: 1'b1, d: 16'h0000};
   localparam resp_t RSP_ILL  = '{s: 1'b1, d: 16'hFFFF};
   localparam resp_t RSP_BERR = '{s: 1'b1, d: 16'h0001};

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
   import dbg_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int REG_W  = 4
) (
   input  logic [WORD_W-1:0] word,
   input  logic              halted,
   output cmd_kind_t         kind,
   output logic [1:0]        size,
   output logic [REG_W-1:0]  reg_idx
);
   localparam int LOW_W = WORD_W - 4;

   logic [3:0]       op;
   logic [LOW_W-1:0] low;
   logic             reg_clean;
   logic             mem_clean;

   if (REG_W >= LOW_W) begin : g_bad_reg
      $error("dbg_cmd_decode: REG_W must be narrower than the operand field");
   end

   assign op        = word[WORD_W-1 -: 4];
   assign low       = word[LOW_W-1:0];
   assign reg_idx   = word[REG_W-1:0];
   assign size      = word[5:4];
   assign reg_clean = (low >> REG_W) == '0;
   assign mem_clean = (low[LOW_W-1:6] == '0) && (low[3:0] == 4'h0) && (word[5:4] != 2'd3);

   always_comb begin
      kind = K_ILL;
      unique case (op)
         OP_NOP:  kind = (low == '0) ? K_NOP : K_ILL;
         OP_RRD:  kind = !reg_clean ? K_ILL : (halted ? K_REGRD : K_REGERR);
         OP_MRD:  kind = mem_clean ? K_MEMRD : K_ILL;
         default: kind = K_ILL;
      endcase
   end
endmodule

// File: rtl/dbg_result_fmt.sv
module dbg_result_fmt
   import dbg_pkg::*;
#(
   parameter int RES_W     = 32,
   parameter int ZERO_FILL = 1
) (
   input  logic [1:0]       size,
   input  logic [RES_W-1:0] raw,
   output logic [RES_W-1:0] fmt
);
   localparam int HALF = RES_W / 2;
   localparam int BYTE = RES_W / 4;

   if (ZERO_FILL != 0) begin : g_fill
      always_comb begin
         unique case (size)
            SZ_BYTE: fmt = {{(RES_W-BYTE){1'b0}}, raw[BYTE-1:0]};
            SZ_WORD: fmt = {{(RES_W-HALF){1'b0}}, raw[HALF-1:0]};
            default: fmt = raw;
         endcase
      end
   end else begin : g_pass
      logic unused_size;
      assign unused_size = ^size;
      assign fmt = raw;
   end
endmodule

// File: rtl/dbg_xfer_gap.sv
module dbg_xfer_gap #(
   parameter int MIN_GAP = 32
) (
   input logic clk,
   input logic rst,
   input logic xfer_valid
);
   localparam int CW = $clog2(MIN_GAP + 1);

   logic [CW-1:0] since_q;

   if (MIN_GAP < 2) begin : g_bad_gap
      $error("dbg_xfer_gap: MIN_GAP must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= CW'(MIN_GAP);
      end else if (xfer_valid) begin
         since_q <= '0;
      end else if (since_q != CW'(MIN_GAP)) begin
         since_q <= since_q + 1'b1;
      end
   end

   // R3: transfers keep the minimum spacing
   a_r3_xfer_spacing: assert property (@(posedge clk) disable iff (rst)
      xfer_valid |-> (since_q >= CW'(MIN_GAP - 1)));
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
   import dbg_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int ADDR_W    = 32,
   parameter int REG_W     = 4,
   parameter int MIN_GAP   = 32,
   parameter int ZERO_FILL = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  core_halted,
   input  logic                  xfer_valid,
   input  logic [WORD_W-1:0]     xfer_word,
   output logic                  resp_valid,
   output logic                  resp_status,
   output logic [WORD_W-1:0]     resp_data,
   output logic                  acc_req,
   output logic                  acc_is_mem,
   output logic [1:0]            acc_size,
   output logic [ADDR_W-1:0]     acc_addr,
   output logic [REG_W-1:0]      acc_reg,
   input  logic                  acc_done,
   input  logic                  acc_err,
   input  logic [2*WORD_W-1:0]   acc_rdata
);
   localparam int RES_W = 2 * WORD_W;

   if (WORD_W != 16) begin : g_bad_word
      $error("dbg_cmd_seq: WORD_W must be 16");
   end
   if (ADDR_W != RES_W) begin : g_bad_addr
      $error("dbg_cmd_seq: ADDR_W must equal two transfer words");
   end

   seq_state_t        st;
   resp_t             pend_q;
   resp_t             resp_q;
   resp_t             resp_sel;
   logic [WORD_W-1:0] ahi_q;
   logic [RES_W-1:0]  res_q;
   logic [RES_W-1:0]  res_fmt;
   cmd_kind_t         dec_kind;
   logic [1:0]        dec_size;
   logic [REG_W-1:0]  dec_reg;
   logic              take_cmd;

   dbg_cmd_decode #(.WORD_W(WORD_W), .REG_W(REG_W)) dec_i (
      .word    (xfer_word),
      .halted  (core_halted),
      .kind    (dec_kind),
      .size    (dec_size),
      .reg_idx (dec_reg)
   );

   dbg_result_fmt #(.RES_W(RES_W), .ZERO_FILL(ZERO_FILL)) fmt_i (
      .size (acc_size),
      .raw  (acc_rdata),
      .fmt  (res_fmt)
   );

   dbg_xfer_gap #(.MIN_GAP(MIN_GAP)) gap_i (
      .clk        (clk),
      .rst        (rst),
      .xfer_valid (xfer_valid)
   );

   // Response prepared before the transfer starts
   always_comb begin
      unique case (st)
         ST_CMD:  resp_sel = pend_q;
         ST_RHI:  resp_sel = '{s: 1'b0, d: res_q[RES_W-1:WORD_W]};
         ST_RLO:  resp_sel = '{s: 1'b0, d: res_q[WORD_W-1:0]};
         default: resp_sel = RSP_NRDY;
      endcase
   end

   assign take_cmd = xfer_valid && ((st == ST_CMD) || (st == ST_RLO));

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_CMD;
         pend_q     <= RSP_NRDY;
         resp_q     <= RSP_NRDY;
         resp_valid <= 1'b0;
         ahi_q      <= '0;
         res_q      <= '0;
         acc_req    <= 1'b0;
         acc_is_mem <= 1'b0;
         acc_size   <= SZ_LONG;
         acc_addr   <= '0;
         acc_reg    <= '0;
      end else begin
         resp_valid <= xfer_valid;
         acc_req    <= 1'b0;
         if (xfer_valid) begin
            resp_q <= resp_sel;
         end
         if (take_cmd) begin
            st <= ST_CMD;
            unique case (dec_kind)
               K_NOP:    pend_q <= RSP_DONE;
               K_REGERR: pend_q <= RSP_BERR;
               K_REGRD: begin
                  acc_req    <= 1'b1;
                  acc_is_mem <= 1'b0;
                  acc_size   <= SZ_LONG;
                  acc_reg    <= dec_reg;
                  st         <= ST_BUSY;
               end
               K_MEMRD: begin
                  acc_size <= dec_size;
                  st       <= ST_AHI;
               end
               default:  pend_q <= RSP_ILL;
            endcase
         end else if (xfer_valid) begin
            unique case (st)
               ST_AHI: begin
                  ahi_q <= xfer_word;
                  st    <= ST_ALO;
               end
               ST_ALO: begin
                  acc_addr   <= {ahi_q, xfer_word};
                  acc_is_mem <= 1'b1;
                  acc_req    <= 1'b1;
                  st         <= ST_BUSY;
               end
               ST_RHI:  st <= ST_RLO;
               default: ;
            endcase
         end
         if ((st == ST_BUSY) && acc_done) begin
            if (acc_err) begin
               pend_q <= RSP_BERR;
               st     <= ST_CMD;
            end else begin
               res_q <= res_fmt;
               st    <= ST_RHI;
            end
         end
      end
   end

   assign resp_status = resp_q.s;
   assign resp_data   = resp_q.d;

   // R9: a transfer during an outstanding access answers not-ready
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && (st == ST_BUSY)) |=> (resp_valid && resp_status && (resp_data == 16'h0000)));

   // R10: a failed access leaves a bus-error answer for the next opcode slot
   a_r10_err_to_cmd: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_BUSY) && acc_done && acc_err) |=> ((st == ST_CMD) && (pend_q == RSP_BERR)));

   // R6: access start is a single-cycle pulse
   a_r6_req_pulse: assert property (@(posedge clk) disable iff (rst)
      acc_req |=> !acc_req);

   // R7: register accesses only start on a halted core
   a_r7_reg_needs_halt: assert property (@(posedge clk) disable iff (rst)
      (acc_req && !acc_is_mem) |-> $past(core_halted));

   // R8: the low address half starts the memory access with that half
   a_r8_mem_launch: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && (st == ST_ALO)) |=>
         (acc_req && acc_is_mem && (acc_addr[WORD_W-1:0] == $past(xfer_word))));

   // R8: completion comes only while an access is outstanding
   a_r8_done_when_busy: assert property (@(posedge clk) disable iff (rst)
      acc_done |-> (st == ST_BUSY));

   // R11: the low result half is answered with status 0
   a_r11_low_half_ok: assert property (@(posedge clk) disable iff (rst)
      (xfer_valid && (st == ST_RLO)) |=> !resp_status);
endmodule

// File: tb/dbg_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_cmd_seq_tb_top;
   localparam int GAP = 32;

   localparam logic [16:0] E_DONE = {1'b0, 16'hFFFF};
   localparam logic [16:0] E_NRDY = {1'b1, 16'h0000};
   localparam logic [16:0] E_ILL  = {1'b1, 16'hFFFF};
   localparam logic [16:0] E_BERR = {1'b1, 16'h0001};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        core_halted = 1'b1;
   logic        xfer_valid = 1'b0;
   logic [15:0] xfer_word = '0;
   logic        resp_valid;
   logic        resp_status;
   logic [15:0] resp_data;
   logic        acc_req;
   logic        acc_is_mem;
   logic [1:0]  acc_size;
   logic [31:0] acc_addr;
   logic [3:0]  acc_reg;
   logic        acc_done = 1'b0;
   logic        acc_err = 1'b0;
   logic [31:0] acc_rdata = '0;

   int          errors = 0;
   int          checks = 0;
   int          req_cnt = 0;
   int          cnt = 0;
   int          m_lat = 1;
   logic        m_err = 1'b0;
   logic        cap_mem = 1'b0;
   logic [31:0] cap_addr = '0;
   logic [3:0]  cap_reg = '0;
   logic [1:0]  cap_size = '0;
   logic [16:0] nxt = '0;

   always #4 clk = ~clk;

   dbg_cmd_seq dut_i (
      .clk(clk), .rst(rst), .core_halted(core_halted),
      .xfer_valid(xfer_valid), .xfer_word(xfer_word),
      .resp_valid(resp_valid), .resp_status(resp_status), .resp_data(resp_data),
      .acc_req(acc_req), .acc_is_mem(acc_is_mem), .acc_size(acc_size),
      .acc_addr(acc_addr), .acc_reg(acc_reg),
      .acc_done(acc_done), .acc_err(acc_err), .acc_rdata(acc_rdata)
   );

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
   endfunction

   function automatic logic [31:0] reg_val(input logic [3:0] r);
      return 32'h5A00_00C3 + 32'h0001_0203 * {28'h0, r};
   endfunction

   // Access responder, driven away from the active edge
   always @(negedge clk) begin
      acc_done = 1'b0;
      acc_err  = 1'b0;
      if (rst) begin
         cnt = 0;
      end else if (acc_req) begin
         req_cnt++;
         cap_mem  = acc_is_mem;
         cap_addr = acc_addr;
         cap_reg  = acc_reg;
         cap_size = acc_size;
         cnt      = m_lat;
      end else if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            acc_done  = 1'b1;
            acc_err   = m_err;
            acc_rdata = cap_mem ? mem_val(cap_addr) : reg_val(cap_reg);
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w, input logic [16:0] exp, input string tag);
      @(negedge clk);
      xfer_valid = 1'b1;
      xfer_word  = w;
      @(negedge clk);
      xfer_valid = 1'b0;
      check(tag, {46'h0, resp_valid, resp_status, resp_data}, {46'h0, 1'b1, exp});
      @(negedge clk);
      check("R3 strobe low between transfers", {63'h0, resp_valid}, 64'h0);
      repeat (GAP - 1) @(negedge clk);
   endtask

   task automatic run_simple(input logic [15:0] w, input logic [16:0] after, input string tag);
      int r0;
      r0 = req_cnt;
      send(w, nxt, tag);
      check("R5 no access for non-access command", 64'(req_cnt), 64'(r0));
      nxt = after;
   endtask

   task automatic run_reg(input logic [3:0] idx, input logic halted, input int nb, input logic err);
      int r0;
      logic [31:0] v;
      core_halted = halted;
      m_lat = nb * (GAP + 2) + GAP / 2;
      m_err = err;
      r0 = req_cnt;
      send(16'h2000 | {12'h0, idx}, nxt, "R11 R1 response in opcode slot");
      if (!halted) begin
         check("R7 no access when running", 64'(req_cnt), 64'(r0));
         nxt = E_BERR;
      end else begin
         check("R6 one register access", {32'(req_cnt), 27'h0, cap_mem, cap_reg, 1'b0},
               {32'(r0 + 1), 27'h0, 1'b0, idx, 1'b0});
         check("R6 register access size long", {62'h0, cap_size}, 64'd2);
         for (int k = 0; k < nb; k++) send(16'h0000, E_NRDY, "R9 busy transfer not-ready");
         if (err) begin
            nxt = E_BERR;
         end else begin
            v = reg_val(idx);
            send(16'hBEEF, {1'b0, v[31:16]}, "R6 register high half");
            nxt = {1'b0, v[15:0]};
         end
      end
      core_halted = 1'b1;
   endtask

   task automatic run_mem(input logic [1:0] sz, input logic [31:0] a, input int nb, input logic err);
      int r0;
      logic [31:0] v;
      logic [31:0] e;
      m_lat = nb * (GAP + 2) + GAP / 2;
      m_err = err;
      r0 = req_cnt;
      send(16'h1000 | {10'h0, sz, 4'h0}, nxt, "R11 R10 response in opcode slot");
      send(a[31:16], E_NRDY, "R8 address high not-ready");
      check("R8 no access before low address", 64'(req_cnt), 64'(r0));
      send(a[15:0], E_NRDY, "R8 address low not-ready");
      check("R8 memory access fields", {cap_addr, 29'h0, cap_mem, cap_size},
            {a, 29'h0, 1'b1, sz});
      check("R8 one memory access", 64'(req_cnt), 64'(r0 + 1));
      for (int k = 0; k < nb; k++) send(16'h0000, E_NRDY, "R9 busy transfer not-ready");
      if (err) begin
         nxt = E_BERR;
      end else begin
         v = mem_val(a);
         if (sz == 2'd0)      e = {24'h0, v[7:0]};
         else if (sz == 2'd1) e = {16'h0, v[15:0]};
         else                 e = v;
         send(16'hBEEF, {1'b0, e[31:16]}, "R12 memory high half");
         nxt = {1'b0, e[15:0]};
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      check("R2 reset outputs idle", {62'h0, resp_valid, acc_req}, 64'h0);
      rst = 1'b0;
      @(negedge clk);
      check("R2 no strobe after reset", {62'h0, resp_valid, acc_req}, 64'h0);
      nxt = E_NRDY;
      run_simple(16'h0000, E_DONE, "R2 first response not-ready");
      run_simple(16'h0000, E_DONE, "R4 R1 complete after no-op");
      for (int op = 3; op < 16; op++)
         run_simple({op[3:0], 12'h0A5}, E_ILL, "R5 R1 prior response");
      run_simple(16'h0001, E_ILL, "R5 illegal after illegal");
      run_simple(16'h2010, E_ILL, "R5 illegal after illegal");
      run_simple(16'h1030, E_ILL, "R5 illegal after illegal");
      run_simple(16'h1001, E_ILL, "R5 illegal after illegal");
      run_simple(16'h1040, E_ILL, "R5 illegal after illegal");
      run_simple(16'h0000, E_DONE, "R5 R1 illegal answer");
      run_reg(4'd5, 1'b0, 0, 1'b0);
      run_simple(16'h0000, E_DONE, "R7 R1 bus error when running");
      for (int r = 0; r < 16; r++) run_reg(r[3:0], 1'b1, 0, 1'b0);
      run_reg(4'd3, 1'b1, 2, 1'b0);
      run_reg(4'd7, 1'b1, 1, 1'b1);
      run_reg(4'd9, 1'b1, 0, 1'b0);
      for (int i = 0; i < 12; i++)
         run_mem(2'(i % 3), 32'h0000_0100 + 32'(i) * 32'h1357_2469,
                 (i % 4 == 3) ? 1 : 0, (i == 5) || (i == 10));
      run_simple(16'h0000, E_DONE, "R11 R12 last low half with opcode");
      run_simple(16'h0000, E_DONE, "R4 complete at end");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule